// File: doc/BRIEF.md
# Scheduled Periodic Pin Toggler

This block turns a free-running fixed-point time value into a periodic output waveform, for example a one-second pulse train. Software supplies an absolute start time and a half-period length, both in the raw units of the time value. Once armed, the block flips its output the first time the time value reaches the start time. In periodic mode it then adds the half-period to the stored edge time and flips again each time the new edge time is reached. In one-shot mode it flips once and stops.

Every edge is found by comparing the incoming time against an absolute edge register, never by dividing a clock. Each reload is an exact addition, so the edges never drift. The comparison is greater-or-equal, so an edge that falls between two increments of the time value is taken on the first sample past it. The output reaches the pad only when the pad is set as an output and its native function is selected; otherwise a general-purpose value is passed through. An optional interrupt can be raised on every output transition. Its cause bit is sticky and is cleared by a one-cycle clear pulse. A separate mask level gates the interrupt line.

Top module: `ckout_gen`

## Requirements
- R1: After reset the waveform is low, pin_oe_o is 0 and irq_o is 0.
- R2: An arm_i pulse while en_i is high loads target_i as the next edge. The first toggle happens at the first rising clock edge after the load where systime_i is greater than or equal to that target, and never earlier.
- R3: An edge that systime_i steps over without matching it exactly is still taken, on the first sample at or past it.
- R4: With periodic_i = 1, each toggle moves the next edge to the previous edge plus period_i, so toggle k lands on the first sample at or past target + k*period.
- R5: With periodic_i = 0, the block toggles exactly once after arming and then stays idle.
- R6: While en_i is low the waveform is forced low and any armed edge is dropped. An arm_i pulse given while en_i is low has no effect once en_i returns high.
- R7: pin_oe_o equals pin_dir_i. pin_o carries the waveform only when pin_dir_i and pin_native_i are both 1; otherwise pin_o equals gpio_i.
- R8: The interrupt cause bit is set on a toggle only when edge_irq_en_i is 1. A toggle with edge_irq_en_i = 0 leaves it clear.
- R9: The cause bit stays set until an irq_clr_i pulse. If a toggle and a clear land in the same cycle, the cause stays set.
- R10: irq_o is the cause bit gated by irq_mask_i. The cause is kept while the mask is low, and irq_o shows it when the mask is raised.
- R11: When the stored edge is already behind systime_i, the block toggles on every clock, one edge per cycle, until the edge passes the time value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| systime_i | input | TW | Current time value from the time counter |
| en_i | input | 1 | Output function enable; low forces the waveform low |
| periodic_i | input | 1 | 1: reload after each edge; 0: single toggle |
| edge_irq_en_i | input | 1 | Set the interrupt cause on each toggle |
| arm_i | input | 1 | One-cycle pulse that loads target_i as the next edge |
| target_i | input | TW | Absolute time of the first edge |
| period_i | input | TW | Half-period added after each edge |
| pin_dir_i | input | 1 | Pad direction: 1 is output |
| pin_native_i | input | 1 | Pad function select: 1 routes the waveform |
| gpio_i | input | 1 | Value driven when the waveform is not routed |
| irq_mask_i | input | 1 | Interrupt line enable |
| irq_clr_i | input | 1 | One-cycle clear of the interrupt cause |
| pin_o | output | 1 | Pad output value |
| pin_oe_o | output | 1 | Pad output enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with TW = 48 and HAS_IRQ = 1. It starts the time value just below 2^32, so that the edge additions and the greater-or-equal comparisons carry across the 32-bit word boundary within a few dozen cycles. The time value advances by 3 per clock while the half-period is 10, so most edges fall between samples. This exercises the step-over rule on nearly every toggle. A start target placed well in the past drives the one-edge-per-cycle catch-up path. The same run also lands a clear pulse on a toggling cycle.

// File: rtl/ckout_pkg.sv
`timescale 1ns/1ps
package ckout_pkg;
  typedef enum logic {
    RUN_ONESHOT  = 1'b0,
    RUN_PERIODIC = 1'b1
  } run_mode_e;

  typedef struct packed {
    logic dir_out;
    logic native;
  } pad_sel_t;
endpackage

// File: rtl/ckout_sched.sv
`timescale 1ns/1ps
module ckout_sched
  import ckout_pkg::*;
#(
  parameter int TW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          arm_i,
  input  run_mode_e     mode_i,
  input  logic [TW-1:0] target_i,
  input  logic [TW-1:0] period_i,
  input  logic [TW-1:0] systime_i,
  output logic          hit_o
);
  logic [TW-1:0] next_q;
  logic          armed_q;

  // arm has priority over a hit in the same cycle
  assign hit_o = en_i & armed_q & ~arm_i & (systime_i >= next_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q  <= '0;
      armed_q <= 1'b0;
    end else if (!en_i) begin
      armed_q <= 1'b0;
    end else if (arm_i) begin
      next_q  <= target_i;
      armed_q <= 1'b1;
    end else if (hit_o) begin
      if (mode_i == RUN_PERIODIC) next_q <= next_q + period_i;
      else                        armed_q <= 1'b0;
    end
  end

  a_r2_edge_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && armed_q && !arm_i && !hit_o) |=> $stable(next_q));
  a_r4_exact_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && mode_i == RUN_PERIODIC) |=> next_q == $past(next_q) + $past(period_i));
  a_r5_single_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && mode_i == RUN_ONESHOT) |=> !armed_q);
  a_r6_drop_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !armed_q);
endmodule

// File: rtl/ckout_irq.sv
`timescale 1ns/1ps
module ckout_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic edge_irq_en_i,
  input  logic clr_i,
  input  logic mask_i,
  output logic irq_o
);
  logic cause_q;
  logic set_w;

  assign set_w = hit_i & edge_irq_en_i;

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cause_q <= 1'b0;
    else if (set_w)  cause_q <= 1'b1;
    else if (clr_i)  cause_q <= 1'b0;
  end

  assign irq_o = cause_q & mask_i;

  a_r8_set_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && edge_irq_en_i) |=> cause_q);
  a_r8_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cause_q && !(hit_i && edge_irq_en_i)) |=> !cause_q);
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_q && !clr_i) |=> cause_q);
endmodule

// File: rtl/ckout_pin.sv
`timescale 1ns/1ps
module ckout_pin
  import ckout_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     hit_i,
  input  pad_sel_t pad_i,
  input  logic     gpio_i,
  output logic     pin_o,
  output logic     pin_oe_o
);
  logic wave_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wave_q <= 1'b0;
    else if (!en_i)  wave_q <= 1'b0;
    else if (hit_i)  wave_q <= ~wave_q;
  end

  assign pin_oe_o = pad_i.dir_out;
  assign pin_o    = (pad_i.dir_out && pad_i.native) ? wave_q : gpio_i;

  a_r6_wave_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !wave_q);
  a_r11_flip_per_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && hit_i) |=> wave_q != $past(wave_q));
  a_r2_hold_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !hit_i) |=> $stable(wave_q));
endmodule

// File: rtl/ckout_gen.sv
`timescale 1ns/1ps
module ckout_gen
  import ckout_pkg::*;
#(
  parameter int TW      = 64,
  parameter bit HAS_IRQ = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] systime_i,
  input  logic          en_i,
  input  logic          periodic_i,
  input  logic          edge_irq_en_i,
  input  logic          arm_i,
  input  logic [TW-1:0] target_i,
  input  logic [TW-1:0] period_i,
  input  logic          pin_dir_i,
  input  logic          pin_native_i,
  input  logic          gpio_i,
  input  logic          irq_mask_i,
  input  logic          irq_clr_i,
  output logic          pin_o,
  output logic          pin_oe_o,
  output logic          irq_o
);
  logic      hit_w;
  run_mode_e mode_w;
  pad_sel_t  pad_w;

  assign mode_w = periodic_i ? RUN_PERIODIC : RUN_ONESHOT;
  assign pad_w  = '{dir_out: pin_dir_i, native: pin_native_i};

  ckout_sched #(.TW(TW)) u_sched (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .arm_i     (arm_i),
    .mode_i    (mode_w),
    .target_i  (target_i),
    .period_i  (period_i),
    .systime_i (systime_i),
    .hit_o     (hit_w)
  );

  ckout_pin u_pin (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .hit_i    (hit_w),
    .pad_i    (pad_w),
    .gpio_i   (gpio_i),
    .pin_o    (pin_o),
    .pin_oe_o (pin_oe_o)
  );

  generate
    if (HAS_IRQ) begin : g_irq
      ckout_irq u_irq (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .hit_i         (hit_w),
        .edge_irq_en_i (edge_irq_en_i),
        .clr_i         (irq_clr_i),
        .mask_i        (irq_mask_i),
        .irq_o         (irq_o)
      );
    end else begin : g_no_irq
      assign irq_o = 1'b0;
    end
  endgenerate

  a_r7_oe_follows_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_o == pin_dir_i);
  a_r10_mask_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_mask_i |-> !irq_o);
endmodule

// File: tb/ckout_gen_test.sv
`timescale 1ns/1ps
module ckout_gen_test;
  localparam int TW = 48;
  localparam logic [TW-1:0] STEP = 3;
  localparam logic [TW-1:0] HALF = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [TW-1:0] st = 48'h0_FFFF_FFA0;
  logic en = 0, periodic = 0, edge_irq_en = 0, arm = 0;
  logic [TW-1:0] target = '0, period = HALF;
  logic pin_dir = 0, pin_native = 0, gpio = 0, irq_mask = 0, irq_clr = 0;
  logic pin_o, pin_oe_o, irq_o;

  int total = 0, bad = 0, tg_cnt = 0;
  bit mon_on = 0, exact = 1, done = 0;
  logic last_pin = 0;
  string mon_req = "R4";
  logic [TW-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  ckout_gen #(.TW(TW), .HAS_IRQ(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .systime_i(st), .en_i(en), .periodic_i(periodic),
    .edge_irq_en_i(edge_irq_en), .arm_i(arm), .target_i(target), .period_i(period),
    .pin_dir_i(pin_dir), .pin_native_i(pin_native), .gpio_i(gpio),
    .irq_mask_i(irq_mask), .irq_clr_i(irq_clr),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o), .irq_o(irq_o));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  task automatic step_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  // monitor: pops an expected edge time on each observed toggle
  always @(negedge clk) begin
    if (mon_on) begin
      if (pin_o != last_pin) begin
        tg_cnt++;
        if (exp_q.size() == 0) begin
          chk(1'b0, {mon_req, " unexpected toggle"}, 64'(st), 64'(0));
        end else begin
          logic [TW-1:0] e;
          e = exp_q.pop_front();
          chk(st >= e, {mon_req, " R3 toggle before edge"}, 64'(st), 64'(e));
          if (exact)
            chk((st - STEP) < e, {mon_req, " R2 toggle late"}, 64'(st), 64'(e));
        end
      end else if (exact && exp_q.size() != 0 && st >= exp_q[0]) begin
        chk(1'b0, {mon_req, " R3 edge missed"}, 64'(st), 64'(exp_q[0]));
        void'(exp_q.pop_front());
      end
    end
    last_pin = pin_o;
    st = st + STEP;
  end

  task automatic wait_drain(input string req);
    int n = 0;
    while (exp_q.size() != 0 && n < 500) begin
      step_n(1);
      n++;
    end
    chk(exp_q.size() == 0, {req, " edges not all produced"}, 64'(exp_q.size()), 64'(0));
    exp_q.delete();
  endtask

  task automatic pulse_arm(input logic [TW-1:0] t);
    target = t;
    arm = 1;
    step_n(1);
    arm = 0;
  endtask

  initial begin
    int base;
    logic [TW-1:0] t0;
    step_n(2);
    rst_ni = 1;
    step_n(1);
    // R1 reset state
    chk(pin_oe_o == 0, "R1 oe", 64'(pin_oe_o), 64'(0));
    chk(irq_o == 0, "R1 irq", 64'(irq_o), 64'(0));
    chk(pin_o == 0, "R1 pin", 64'(pin_o), 64'(0));
    // R7 routing
    pin_dir = 1; gpio = 1; step_n(1);
    chk(pin_o == 1, "R7 gpio passthrough", 64'(pin_o), 64'(1));
    chk(pin_oe_o == 1, "R7 oe", 64'(pin_oe_o), 64'(1));
    pin_native = 1; step_n(1);
    chk(pin_o == 0, "R7 R1 waveform routed low", 64'(pin_o), 64'(0));

    // R4 periodic, edges crossing the 32-bit boundary
    en = 1; periodic = 1; edge_irq_en = 1; irq_mask = 0;
    t0 = st + 20;
    for (int k = 0; k < 8; k++) exp_q.push_back(t0 + HALF * k);
    mon_req = "R4"; exact = 1; mon_on = 1;
    pulse_arm(t0);
    wait_drain("R4");
    mon_on = 0;
    chk(irq_o == 0, "R10 masked", 64'(irq_o), 64'(0));
    irq_mask = 1; step_n(1);
    chk(irq_o == 1, "R10 cause kept while masked", 64'(irq_o), 64'(1));
    en = 0; step_n(1);
    chk(pin_o == 0, "R6 disable forces low", 64'(pin_o), 64'(0));
    step_n(5);
    chk(irq_o == 1, "R9 sticky", 64'(irq_o), 64'(1));
    irq_clr = 1; step_n(1); irq_clr = 0; step_n(1);
    chk(irq_o == 0, "R9 cleared", 64'(irq_o), 64'(0));

    // R6 arm while disabled is ignored
    pulse_arm(st + 5);
    en = 1; step_n(20);
    chk(pin_o == 0, "R6 arm ignored", 64'(pin_o), 64'(0));

    // R5 one-shot, R8 no irq without edge enable
    periodic = 0; edge_irq_en = 0;
    t0 = st + 23;
    exp_q.push_back(t0);
    mon_req = "R5"; exact = 1; mon_on = 1;
    pulse_arm(t0);
    wait_drain("R5");
    base = tg_cnt;
    step_n(40);
    chk(tg_cnt == base, "R5 no further toggle", 64'(tg_cnt - base), 64'(0));
    chk(pin_o == 1, "R5 level held", 64'(pin_o), 64'(1));
    chk(irq_o == 0, "R8 no cause without enable", 64'(irq_o), 64'(0));
    mon_on = 0;
    en = 0; step_n(1); en = 1; step_n(1);

    // R11 catch-up, R9 set wins over clear
    periodic = 1; edge_irq_en = 1;
    t0 = st - 100;
    for (int k = 0; k < 8; k++) exp_q.push_back(t0 + HALF * k);
    mon_req = "R11"; exact = 0; mon_on = 1;
    base = tg_cnt;
    target = t0; arm = 1; step_n(1);
    arm = 0; irq_clr = 1; step_n(1);
    irq_clr = 0;
    chk(irq_o == 1, "R9 set beats clear", 64'(irq_o), 64'(1));
    step_n(3);
    chk(tg_cnt - base == 4, "R11 one toggle per cycle", 64'(tg_cnt - base), 64'(4));
    wait_drain("R11");
    mon_on = 0; en = 0;
    step_n(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule